// File: doc/BRIEF.md
# Multi-channel edge-aligned PWM timer

The block drives several pulse-width-modulated outputs from one shared up-counter. A prescaler slows the input clock, and the counter steps once per prescaler period from zero up to a shared reload limit, then wraps. Each channel compares the counter against its own compare value. While the counter is below that value, the channel's internal level is active. A polarity bit picks the pin level, and an optional complementary pin carries the opposite phase with its own enable and polarity.

Software programs the block through a write-only port. The prescaler and the compare values sit in staging registers. They reach the working copies only at an update event. An update event is a counter wrap or a software strobe, so a duty or rate change never cuts a period short. The reload limit is staged the same way when the staging bit is set, and takes effect at once when it is clear. A compare value one above the reload limit holds the output active for the whole period, which gives 100 % duty. Setting the polarity bit and loading the compare with reload+1-duty moves the active time to the end of the period.

Top module: `mpwm_timer`

## Requirements
- R1: While `rst_n` is low and after its release, `cnt`, `pwm` and `pwmn` are all zero and the counter stays stopped until the run bit is written.
- R2: With the run bit set, `cnt` steps by one every PSC+1 clocks, counting from 0 up to the reload limit ARR and then returning to 0, so one period lasts (PSC+1)*(ARR+1) clocks.
- R3: A channel's internal level is active while `cnt` is below the working compare value. Compare 0 is never active. Any compare of ARR+1 or more is active for the whole period. `pwm`, `pwmn` and `cnt` change on the same clock edge.
- R4: `pwm[i]` equals (main enable i AND internal level) XOR main polarity i. A disabled channel therefore drives its polarity bit. A change to an enable or polarity bit reaches the pin one clock after the write.
- R5: `pwmn[i]` equals (complementary enable i AND NOT internal level) XOR complementary polarity i.
- R6: Writes to PSC and to the compare registers land in staging registers. They change the output timing only from the next update event, which is a wrap from ARR to 0 or a software strobe.
- R7: With the staging bit set, a write to ARR takes effect at the next update event. With it clear, the write takes effect on the next clock. If the counter is already at or above the new limit, it wraps at its next step.
- R8: Writing CTRL with bit 2 set forces an update event. All staged values are copied to the working registers, and the prescaler and the counter restart from 0, whether or not the run bit is set. Bit 2 is not stored, so a later CTRL write without it causes no update.
- R9: The counter advances only while the run bit is set and holds its value otherwise. A write to the enable register that leaves every main enable bit at zero clears the run bit.
- R10: Register map at `wr_addr`: 0 CTRL (bit 0 run, bit 1 staging enable for ARR, bit 2 update strobe), 1 PSC, 2 ARR, 3 enables (bits [N-1:0] main, [2N-1:N] complementary), 4 polarity (same layout), 8+i compare of channel i. Writes to any other address, or to a compare address of a channel that does not exist, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | CNT_W | Write data |
| cnt | output | CNT_W | Current counter value |
| pwm | output | CH_N | Main channel outputs |
| pwmn | output | CH_N | Complementary channel outputs |

## Verification
On every cycle, the assertions check the following:
- the counter's single steps and wraps;
- that the counter freezes while stopped;
- the restart after a strobe;
- that the working compare values stay put between update events;
- the level of disabled channels;
- the automatic clearing of the run bit.

Only the bench's scenarios show the full waveform. Its sweeps over small prescaler, reload and compare settings compare every counter value and every pin against an arithmetic model. That includes the 0 % and 100 % duty corners, staged and direct reload changes in mid-period, and ignored writes.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_PSC  = 4'd1;
  localparam logic [ADDR_W-1:0] A_ARR  = 4'd2;
  localparam logic [ADDR_W-1:0] A_EN   = 4'd3;
  localparam logic [ADDR_W-1:0] A_POL  = 4'd4;
  localparam int unsigned       A_CMP0 = 8;

  localparam int unsigned CTRL_RUN = 0;
  localparam int unsigned CTRL_STG = 1;
  localparam int unsigned CTRL_UPD = 2;
endpackage

// File: rtl/mpwm_regs.sv
module mpwm_regs
  import mpwm_pkg::*;
#(
  parameter int unsigned CH_N  = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [CNT_W-1:0]                wr_data,
  output logic                            run_q,
  output logic                            sw_upd,
  output logic                            arr_direct,
  output logic [CNT_W-1:0]                psc_q,
  output logic [CNT_W-1:0]                arr_q,
  output logic [CH_N-1:0][CNT_W-1:0]      cmp_q,
  output logic [2*CH_N-1:0]               en_q,
  output logic [2*CH_N-1:0]               pol_q
);
  localparam int unsigned EN_W = 2 * CH_N;

  logic              stg_q;
  logic              run_d, stg_d;
  logic              ctrl_we, psc_we, arr_we, en_we, pol_we;
  logic [EN_W-1:0]   en_d;

  assign ctrl_we    = wr_en && (wr_addr == A_CTRL);
  assign psc_we     = wr_en && (wr_addr == A_PSC);
  assign arr_we     = wr_en && (wr_addr == A_ARR);
  assign en_we      = wr_en && (wr_addr == A_EN);
  assign pol_we     = wr_en && (wr_addr == A_POL);

  assign sw_upd     = ctrl_we && wr_data[CTRL_UPD];
  assign arr_direct = arr_we && !stg_q;

  // next-state for control bits
  always_comb begin
    run_d = run_q;
    stg_d = stg_q;
    en_d  = en_q;
    if (ctrl_we) begin
      run_d = wr_data[CTRL_RUN];
      stg_d = wr_data[CTRL_STG];
    end
    if (en_we) begin
      en_d = wr_data[EN_W-1:0];
      if (wr_data[CH_N-1:0] == '0) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      stg_q <= 1'b0;
    end else if (ctrl_we || en_we) begin
      run_q <= run_d;
      stg_q <= stg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pol_q <= '0;
    else if (pol_we) pol_q <= wr_data[EN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      psc_q <= '0;
    else if (psc_we) psc_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      arr_q <= '0;
    else if (arr_we) arr_q <= wr_data;
  end

  for (genvar i = 0; i < CH_N; i++) begin : g_cmp
    logic cmp_we;
    assign cmp_we = wr_en && (wr_addr == ADDR_W'(A_CMP0 + i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmp_q[i] <= '0;
      else if (cmp_we) cmp_q[i] <= wr_data;
    end
  end
endmodule

// File: rtl/mpwm_timebase.sv
module mpwm_timebase #(
  parameter int unsigned CH_N  = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        run,
  input  logic                        sw_upd,
  input  logic                        arr_direct,
  input  logic [CNT_W-1:0]            arr_wdata,
  input  logic [CNT_W-1:0]            psc_stg,
  input  logic [CNT_W-1:0]            arr_stg,
  input  logic [CH_N-1:0][CNT_W-1:0]  cmp_stg,
  output logic [CNT_W-1:0]            cnt_q,
  output logic [CNT_W-1:0]            cnt_d,
  output logic [CNT_W-1:0]            pcnt_q,
  output logic [CNT_W-1:0]            arr_act_q,
  output logic [CH_N-1:0][CNT_W-1:0]  cmp_act_q,
  output logic [CH_N-1:0][CNT_W-1:0]  cmp_act_d,
  output logic                        tick,
  output logic                        update
);
  logic [CNT_W-1:0] pcnt_d;
  logic [CNT_W-1:0] psc_act_q, psc_act_d;
  logic [CNT_W-1:0] arr_act_d;
  logic             wrap;
  logic             cnt_ce, lim_ce;

  assign tick   = run && (pcnt_q == psc_act_q);
  assign wrap   = tick && (cnt_q >= arr_act_q);
  assign update = sw_upd || wrap;
  assign cnt_ce = sw_upd || run;
  assign lim_ce = update || arr_direct;

  // counter next state
  always_comb begin
    pcnt_d = pcnt_q;
    cnt_d  = cnt_q;
    if (sw_upd) begin
      pcnt_d = '0;
      cnt_d  = '0;
    end else if (run) begin
      if (tick) begin
        pcnt_d = '0;
        cnt_d  = wrap ? '0 : cnt_q + 1'b1;
      end else begin
        pcnt_d = pcnt_q + 1'b1;
      end
    end
  end

  // working limits next state
  always_comb begin
    psc_act_d = update ? psc_stg : psc_act_q;
    if (arr_direct)  arr_act_d = arr_wdata;
    else if (update) arr_act_d = arr_stg;
    else             arr_act_d = arr_act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pcnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q  <= cnt_d;
      pcnt_q <= pcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_act_q <= '0;
      arr_act_q <= '0;
    end else if (lim_ce) begin
      psc_act_q <= psc_act_d;
      arr_act_q <= arr_act_d;
    end
  end

  for (genvar i = 0; i < CH_N; i++) begin : g_cmp
    assign cmp_act_d[i] = update ? cmp_stg[i] : cmp_act_q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmp_act_q[i] <= '0;
      else if (update) cmp_act_q[i] <= cmp_act_d[i];
    end
  end
endmodule

// File: rtl/mpwm_channel.sv
module mpwm_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [CNT_W-1:0] cmp_d,
  input  logic             en_main,
  input  logic             en_comp,
  input  logic             pol_main,
  input  logic             pol_comp,
  output logic             pwm_q,
  output logic             pwmn_q
);
  logic act, pwm_d, pwmn_d;

  always_comb begin
    act    = cnt_d < cmp_d;
    pwm_d  = (en_main & act) ^ pol_main;
    pwmn_d = (en_comp & ~act) ^ pol_comp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q  <= 1'b0;
      pwmn_q <= 1'b0;
    end else begin
      pwm_q  <= pwm_d;
      pwmn_q <= pwmn_d;
    end
  end
endmodule

// File: rtl/mpwm_timer.sv
module mpwm_timer
  import mpwm_pkg::*;
#(
  parameter int unsigned CH_N  = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  cnt,
  output logic [CH_N-1:0]   pwm,
  output logic [CH_N-1:0]   pwmn
);
  logic                        run, sw_upd, arr_direct, tick, update;
  logic [CNT_W-1:0]            psc_stg, arr_stg, cnt_nxt, pcnt, arr_act;
  logic [CH_N-1:0][CNT_W-1:0]  cmp_stg, cmp_act, cmp_nxt;
  logic [2*CH_N-1:0]           en_vec, pol_vec;

  mpwm_regs #(.CH_N(CH_N), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run_q(run), .sw_upd(sw_upd), .arr_direct(arr_direct),
    .psc_q(psc_stg), .arr_q(arr_stg), .cmp_q(cmp_stg),
    .en_q(en_vec), .pol_q(pol_vec)
  );

  mpwm_timebase #(.CH_N(CH_N), .CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(run), .sw_upd(sw_upd),
    .arr_direct(arr_direct), .arr_wdata(wr_data),
    .psc_stg(psc_stg), .arr_stg(arr_stg), .cmp_stg(cmp_stg),
    .cnt_q(cnt), .cnt_d(cnt_nxt), .pcnt_q(pcnt), .arr_act_q(arr_act),
    .cmp_act_q(cmp_act), .cmp_act_d(cmp_nxt), .tick(tick), .update(update)
  );

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    mpwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .cnt_d(cnt_nxt), .cmp_d(cmp_nxt[i]),
      .en_main(en_vec[i]), .en_comp(en_vec[CH_N+i]),
      .pol_main(pol_vec[i]), .pol_comp(pol_vec[CH_N+i]),
      .pwm_q(pwm[i]), .pwmn_q(pwmn[i])
    );
  end
endmodule

// File: rtl/mpwm_checker.sv
module mpwm_checker
  import mpwm_pkg::*;
#(
  parameter int unsigned CH_N  = 4,
  parameter int unsigned CNT_W = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic [3:0]                  wr_addr,
  input logic [CH_N-1:0]             wr_main,
  input logic                        run,
  input logic                        sw_upd,
  input logic                        tick,
  input logic                        update,
  input logic [CNT_W-1:0]            cnt,
  input logic [CNT_W-1:0]            pcnt,
  input logic [CNT_W-1:0]            arr_act,
  input logic [CH_N-1:0][CNT_W-1:0]  cmp_act,
  input logic [2*CH_N-1:0]           en_vec,
  input logic [2*CH_N-1:0]           pol_vec,
  input logic [CH_N-1:0]             pwm
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !sw_upd && cnt < arr_act) |=> (cnt == $past(cnt) + 1'b1));

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !sw_upd && cnt >= arr_act) |=> (cnt == '0));

  p_cmp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> $stable(cmp_act));

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_upd |=> (cnt == '0 && pcnt == '0));

  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !sw_upd) |=> $stable(cnt));

  p_run_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_EN && wr_main == '0) |=> !run);

  for (genvar i = 0; i < CH_N; i++) begin : g_lvl
    p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !en_vec[i] |=> (pwm[i] == $past(pol_vec[i])));
  end
endmodule

bind mpwm_timer mpwm_checker #(.CH_N(CH_N), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_main(wr_data[CH_N-1:0]), .run(run), .sw_upd(sw_upd), .tick(tick),
  .update(update), .cnt(cnt), .pcnt(pcnt), .arr_act(arr_act),
  .cmp_act(cmp_act), .en_vec(en_vec), .pol_vec(pol_vec), .pwm(pwm)
);

// File: tb/mpwm_timer_test.sv
`timescale 1ns/1ps
module mpwm_timer_test;
  localparam int N = 4;
  localparam int W = 16;
  localparam logic [3:0] R_CTRL = 4'd0, R_PSC = 4'd1, R_ARR = 4'd2,
                         R_EN = 4'd3, R_POL = 4'd4, R_CMP = 4'd8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] cnt;
  logic [N-1:0] pwm, pwmn;

  int n_chk = 0;
  int n_err = 0;
  bit chk_on = 0;
  bit done = 0;
  string tag_cnt = "R1";
  string tag_out = "R1";

  mpwm_timer #(.CH_N(N), .CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt(cnt), .pwm(pwm), .pwmn(pwmn)
  );

  always #5 clk = ~clk;

  // arithmetic model built from the requirements
  logic m_run, m_stg, m_tk, m_wrap, m_upd, m_act;
  logic [W-1:0] m_psc, m_arr, m_pc, m_c, m_psca, m_arra;
  logic [W-1:0] m_cmp [N];
  logic [W-1:0] m_cmpa [N];
  logic [2*N-1:0] m_en, m_pol;
  logic [N-1:0] e_pwm, e_pwmn;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_stg = 0; m_psc = 0; m_arr = 0; m_pc = 0; m_c = 0;
      m_psca = 0; m_arra = 0; m_en = 0; m_pol = 0; e_pwm = 0; e_pwmn = 0;
      for (int i = 0; i < N; i++) begin m_cmp[i] = 0; m_cmpa[i] = 0; end
    end else begin
      m_tk   = m_run && (m_pc == m_psca);
      m_wrap = m_tk && (m_c >= m_arra);
      m_upd  = (wr_en && wr_addr == R_CTRL && wr_data[2]) || m_wrap;
      if (wr_en && wr_addr == R_CTRL && wr_data[2]) begin
        m_pc = 0; m_c = 0;
      end else if (m_run) begin
        if (m_tk) begin m_pc = 0; m_c = m_wrap ? 16'd0 : m_c + 16'd1; end
        else m_pc = m_pc + 16'd1;
      end
      if (m_upd) begin
        m_psca = m_psc; m_arra = m_arr;
        for (int i = 0; i < N; i++) m_cmpa[i] = m_cmp[i];
      end
      if (wr_en && wr_addr == R_ARR && !m_stg) m_arra = wr_data;
      for (int i = 0; i < N; i++) begin
        m_act = m_c < m_cmpa[i];
        e_pwm[i]  = (m_en[i] & m_act) ^ m_pol[i];
        e_pwmn[i] = (m_en[N+i] & ~m_act) ^ m_pol[N+i];
      end
      if (wr_en) begin
        case (wr_addr)
          R_CTRL: begin m_run = wr_data[0]; m_stg = wr_data[1]; end
          R_PSC:  m_psc = wr_data;
          R_ARR:  m_arr = wr_data;
          R_EN:   begin m_en = wr_data[2*N-1:0]; if (wr_data[N-1:0] == 0) m_run = 0; end
          R_POL:  m_pol = wr_data[2*N-1:0];
          default: if (wr_addr >= R_CMP && wr_addr < R_CMP + N) m_cmp[wr_addr - R_CMP] = wr_data;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      chk(tag_cnt, 32'(cnt), 32'(m_c));
      chk(tag_out, 32'(pwm), 32'(e_pwm));
      chk("R5", 32'(pwmn), 32'(e_pwmn));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 32'(cnt), 0);
    chk("R1", 32'(pwm), 0);
    chk("R1", 32'(pwmn), 0);
    rst_n = 1'b1;
    chk_on = 1;
    idle(4);

    // sweep of prescaler, limit and compare (0 .. ARR+1), both polarities
    tag_cnt = "R2";
    for (int p = 0; p < 3; p++)
      for (int a = 0; a < 5; a++)
        for (int k = 0; k < 2; k++) begin
          tag_out = (k == 0) ? "R3" : "R4";
          wr(R_PSC, W'(p));
          wr(R_ARR, W'(a));
          for (int i = 0; i < N; i++) wr(R_CMP + 4'(i), W'((i + 2 * k) % (a + 2)));
          wr(R_EN, (k == 0) ? 16'h00FF : 16'h00A5);
          wr(R_POL, (k == 0) ? 16'h0000 : 16'h003C);
          wr(R_CTRL, 16'h0007);
          idle(2 * (p + 1) * (a + 1) + 1);
        end

    // staged compare and prescaler
    tag_cnt = "R6"; tag_out = "R6";
    wr(R_PSC, 16'd0); wr(R_ARR, 16'd7);
    wr(R_CMP + 4'd0, 16'd2); wr(R_CMP + 4'd1, 16'd4);
    wr(R_CMP + 4'd2, 16'd6); wr(R_CMP + 4'd3, 16'd8);
    wr(R_EN, 16'h00FF); wr(R_POL, 16'h0000);
    wr(R_CTRL, 16'h0007);
    idle(3);
    wr(R_CMP + 4'd1, 16'd7); wr(R_PSC, 16'd1);
    idle(30);

    // staged and direct reload
    tag_cnt = "R7"; tag_out = "R3";
    wr(R_ARR, 16'd3);
    idle(20);
    tag_cnt = "R8";
    wr(R_CTRL, 16'h0001);
    idle(5);
    tag_cnt = "R7";
    wr(R_ARR, 16'd1);
    idle(10);
    wr(R_ARR, 16'd6);
    idle(20);

    // strobe in mid-period
    tag_cnt = "R8";
    wr(R_CTRL, 16'h0007);
    idle(7);
    wr(R_CTRL, 16'h0003);
    idle(12);

    // ignored writes
    tag_cnt = "R10"; tag_out = "R10";
    wr(4'd5, 16'hFFFF); wr(4'd7, 16'h1234);
    wr(R_CMP + 4'd7, 16'h0000); wr(4'd6, 16'h0000);
    idle(10);

    // stop by clearing all main enables; idle levels follow polarity
    tag_cnt = "R9"; tag_out = "R9";
    wr(R_EN, 16'h00F0);
    idle(10);
    tag_out = "R4";
    wr(R_POL, 16'h00FF);
    idle(4);
    tag_cnt = "R9";
    wr(R_CTRL, 16'h0001);
    idle(10);
    wr(R_CTRL, 16'h0000);
    idle(6);

    done = 1;
    chk_on = 0;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule